// File: doc/BRIEF.md
# Grouped Level-Interrupt Combiner

This block sorts a wide vector of level-sensitive interrupt sources into groups of eight. Each group has one output line toward a parent interrupt controller. A group's line is high whenever at least one of its sources is both enabled and high. Four neighbouring groups share one 32-bit register bank, so the bank holds 32 enable bits. Banks sit back to back in the address space, 16 bytes apart.

Software changes enables through two write-only style registers:
- One register sets enable bits: each written 1 enables a source.
- The other clears enable bits: each written 1 disables a source.

Zero bits in either write leave the enables as they are. A third register returns the raw source levels of the bank.

The number of groups is a build parameter. A variant parameter caps it at 16 groups (narrow build) or 32 groups (wide build). When the group count is not a multiple of four, the last bank is only partly populated.

Top module: `grpirq_combiner`

## Requirements
- R1: After a synchronous active-low reset, every enable bit is 0, every `grp_irq` bit is 0 and `reg_rdata` is 0.
- R2: A write to byte offset 0x0 of a bank sets each enable bit whose write-data bit is 1; the new enables are in effect from the clock edge that accepts the write.
- R3: A write to byte offset 0x4 of a bank clears each enable bit whose write-data bit is 1.
- R4: Write-data bits that are 0 at offset 0x0 or 0x4 leave the matching enable bits unchanged, so successive set writes accumulate.
- R5: Group g lives in bank g/4, at byte address (g/4)*0x10, and owns bits (g mod 4)*8 to (g mod 4)*8+7 of that bank's registers. Bit i of that lane belongs to source `src_lvl[g*8+i]`, and `grp_irq[g]` reflects only that group.
- R6: `grp_irq[g]` is the OR over the group's sources of (enable AND level). It follows source levels in the same cycle, with no register on the path, and stays high while any enabled source of the group is high.
- R7: A read at offset 0xC returns the raw levels of the bank's 32 sources, whether or not they are enabled, as seen at the accepting clock edge.
- R8: Reads at offset 0x0 and at offset 0x4 both return the bank's current enable bits. Read data appears on `reg_rdata` after the accepting edge and holds until the next read.
- R9: Reads of any offset other than 0x0, 0x4 and 0xC, and reads of banks beyond the last one, return 0. Writes there, and writes to offset 0xC, change no enable bit.
- R10: Lanes past `GROUP_COUNT` in the last bank have no storage: their enable bits stay 0 and read back as 0, and their status bits read as 0. `GROUP_COUNT` above 16 (narrow variant) or 32 (wide variant) is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_lvl | input | GROUP_COUNT*8 | Level interrupt sources, eight per group |
| reg_en | input | 1 | Register access strobe, one access per cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address: bank in the upper bits, offset in bits 3:0 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| grp_irq | output | GROUP_COUNT | One combined interrupt line per group |

## Verification
A corrupted enable bit shows up in two places. A readback at offset 0x0 or 0x4 exposes it one cycle after the read. It also appears on the owning `grp_irq` line in the same cycle as soon as that source goes high. A wrong lane or bank decode sends a source's effect to a neighbouring group, which the bench catches by walking one source through every group in turn. A mis-decoded or unguarded offset shows as nonzero read data, or as an enable change, on the very next access.

// File: rtl/grpirq_pkg.sv
// Shared constants and types for the grouped interrupt combiner.
// Assumes 32-bit banks made of four 8-source lanes.
package grpirq_pkg;
    localparam int LANE_W     = 8;
    localparam int LANES      = 4;
    localparam int BANK_W     = LANE_W * LANES;
    localparam int OFS_W      = 4;
    localparam logic [OFS_W-1:0] OFS_SET  = 4'h0;
    localparam logic [OFS_W-1:0] OFS_CLR  = 4'h4;
    localparam logic [OFS_W-1:0] OFS_STAT = 4'hC;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_SET  = 2'd1,
        RK_CLR  = 2'd2,
        RK_STAT = 2'd3
    } reg_kind_e;
endpackage

// File: rtl/grpirq_decode.sv
// Address decoder: splits a byte address into a bank index and a register
// kind. Assumes banks are 16 bytes apart and that offsets must match exactly.
module grpirq_decode
    import grpirq_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int BANK_COUNT = 8,
    localparam int IDX_W     = ADDR_W - OFS_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  bank_idx,
    output reg_kind_e         kind
);
    logic in_range;

    assign bank_idx = addr[ADDR_W-1:OFS_W];
    assign in_range = (int'(bank_idx) < BANK_COUNT);

    // Map offset to register kind; anything out of range is undecoded.
    always_comb begin
        kind = RK_NONE;
        if (in_range) begin
            case (addr[OFS_W-1:0])
                OFS_SET:  kind = RK_SET;
                OFS_CLR:  kind = RK_CLR;
                OFS_STAT: kind = RK_STAT;
                default:  kind = RK_NONE;
            endcase
        end
    end
endmodule

// File: rtl/grpirq_bank.sv
// One register bank: 32 enable bits in four 8-bit lanes, a set/clear write
// path, a raw status view and one OR-reduced output per lane. Lanes at or
// above LIVE_LANES hold no state and report zero.
module grpirq_bank
    import grpirq_pkg::*;
#(
    parameter int LIVE_LANES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_set,
    input  logic              wr_clr,
    input  logic [BANK_W-1:0] wdata,
    input  logic [BANK_W-1:0] src,
    output logic [BANK_W-1:0] en_q,
    output logic [BANK_W-1:0] stat,
    output logic [LANES-1:0]  irq
);
    localparam logic [BANK_W-1:0] LIVE_MASK =
        (LIVE_LANES >= LANES) ? {BANK_W{1'b1}}
                              : BANK_W'((64'd1 << (LIVE_LANES * LANE_W)) - 64'd1);

    // Enable storage: set has ones-to-enable, clear has ones-to-disable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (wr_set)
            en_q <= en_q | (wdata & LIVE_MASK);
        else if (wr_clr)
            en_q <= en_q & ~wdata;
    end

    // Status view: raw levels of populated lanes only.
    assign stat = src & LIVE_MASK;

    // Per-lane OR of enabled, pending sources.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign irq[l] = |(en_q[l*LANE_W +: LANE_W] & src[l*LANE_W +: LANE_W]);
    end

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((en_q & $past(wdata) & LIVE_MASK) == ($past(wdata) & LIVE_MASK))); // R2
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && !wr_set) |=> ((en_q & $past(wdata)) == '0)); // R3
    AST_ZERO_BITS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set || wr_clr) |=> ((en_q & ~$past(wdata)) == ($past(en_q) & ~$past(wdata)))); // R4
endmodule

// File: rtl/grpirq_combiner.sv
// Grouped level-interrupt combiner top. Packs GROUP_COUNT groups of eight
// sources into 32-bit banks at 0x10 strides, decodes one register access per
// cycle and drives one combined line per group. Assumes at most one access
// per cycle and level-held sources.
module grpirq_combiner
    import grpirq_pkg::*;
#(
    parameter int  GROUP_COUNT = 32,
    parameter bit  WIDE_BUILD  = 1'b1,
    parameter int  ADDR_W      = 8,
    localparam int NUM_SRC     = GROUP_COUNT * LANE_W,
    localparam int BANK_COUNT  = (GROUP_COUNT + LANES - 1) / LANES,
    localparam int MAX_GROUPS  = WIDE_BUILD ? 32 : 16,
    localparam int IDX_W       = ADDR_W - OFS_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_SRC-1:0]     src_lvl,
    input  logic                   reg_en,
    input  logic                   reg_we,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [BANK_W-1:0]      reg_wdata,
    output logic [BANK_W-1:0]      reg_rdata,
    output logic [GROUP_COUNT-1:0] grp_irq
);
    if (GROUP_COUNT < 1 || GROUP_COUNT > MAX_GROUPS) begin : g_bad_count
        $error("GROUP_COUNT out of range for the selected variant");
    end
    if ((1 << IDX_W) < BANK_COUNT) begin : g_bad_addr
        $error("ADDR_W too small for the bank count");
    end

    logic [IDX_W-1:0]              bank_idx;
    reg_kind_e                     kind;
    logic [BANK_COUNT*BANK_W-1:0]  src_pad;
    logic [BANK_COUNT*BANK_W-1:0]  en_flat;
    logic [BANK_COUNT*BANK_W-1:0]  stat_flat;
    logic [BANK_COUNT*LANES-1:0]   irq_flat;
    logic [BANK_W-1:0]             rd_next;

    grpirq_decode #(.ADDR_W(ADDR_W), .BANK_COUNT(BANK_COUNT)) u_dec (
        .addr     (reg_addr),
        .bank_idx (bank_idx),
        .kind     (kind)
    );

    // Zero-extend the sources to whole banks.
    always_comb begin
        src_pad = '0;
        src_pad[NUM_SRC-1:0] = src_lvl;
    end

    for (genvar k = 0; k < BANK_COUNT; k++) begin : g_bank
        localparam int LEFT = GROUP_COUNT - k * LANES;
        localparam int LIVE = (LEFT >= LANES) ? LANES : LEFT;
        logic hit;
        assign hit = reg_en && reg_we && (int'(bank_idx) == k);

        grpirq_bank #(.LIVE_LANES(LIVE)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_set (hit && (kind == RK_SET)),
            .wr_clr (hit && (kind == RK_CLR)),
            .wdata  (reg_wdata),
            .src    (src_pad[k*BANK_W +: BANK_W]),
            .en_q   (en_flat[k*BANK_W +: BANK_W]),
            .stat   (stat_flat[k*BANK_W +: BANK_W]),
            .irq    (irq_flat[k*LANES +: LANES])
        );
    end

    assign grp_irq = irq_flat[GROUP_COUNT-1:0];

    // Read mux: enables for set/clear offsets, raw levels for status.
    always_comb begin
        rd_next = '0;
        for (int k = 0; k < BANK_COUNT; k++) begin
            if (int'(bank_idx) == k) begin
                case (kind)
                    RK_SET, RK_CLR: rd_next = en_flat[k*BANK_W +: BANK_W];
                    RK_STAT:        rd_next = stat_flat[k*BANK_W +: BANK_W];
                    default:        rd_next = '0;
                endcase
            end
        end
    end

    // Read data register: loads on reads, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_en && !reg_we)
            reg_rdata <= rd_next;
    end

    AST_UNDEC_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && !reg_we && kind == RK_NONE) |=> (reg_rdata == '0)); // R9
    AST_STATUS_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && reg_we && (kind == RK_STAT || kind == RK_NONE)) |=> $stable(en_flat)); // R9
endmodule

// File: tb/sim_grpirq_combiner.sv
// Directed bench: 10 groups in the narrow build, so the third bank is half
// populated. Each task drives one scenario and checks its own results.
module sim_grpirq_combiner;
    localparam int NG   = 10;
    localparam int NS   = NG * 8;
    localparam int AW   = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_lvl = '0;
    logic          reg_en = 1'b0;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NG-1:0] grp_irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    grpirq_combiner #(.GROUP_COUNT(NG), .WIDE_BUILD(1'b0), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .reg_en(reg_en),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .grp_irq(grp_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_en = 1'b0;
        d = reg_rdata;
    endtask

    task automatic clear_all();
        for (int b = 0; b < 3; b++) wr(AW'(b * 16 + 4), 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq after reset", 32'(grp_irq), 32'h0);
        chk("R1 rdata after reset", reg_rdata, 32'h0);
        rd(8'h10, d);
        chk("R1 enables after reset", d, 32'h0);
    endtask

    task automatic t_set_clear();
        logic [31:0] d;
        wr(8'h00, 32'h8000_0011);
        rd(8'h00, d);
        chk("R2 set bits", d, 32'h8000_0011);
        rd(8'h04, d);
        chk("R8 clear offset reads enables", d, 32'h8000_0011);
        wr(8'h00, 32'h0000_0100);
        rd(8'h00, d);
        chk("R4 set accumulates", d, 32'h8000_0111);
        wr(8'h04, 32'h0000_0010);
        rd(8'h00, d);
        chk("R3 clear bit", d, 32'h8000_0101);
        wr(8'h04, 32'h0);
        rd(8'h04, d);
        chk("R4 zero clear keeps", d, 32'h8000_0101);
        clear_all();
    endtask

    task automatic t_map();
        for (int g = 0; g < NG; g++) begin
            int b = g / 4;
            int bit_pos = (g % 4) * 8 + (g % 8);
            @(negedge clk);
            src_lvl = '0;
            src_lvl[g * 8 + (g % 8)] = 1'b1;
            wr(AW'(b * 16), 32'h1 << bit_pos);
            #1;
            chk($sformatf("R5 group %0d line", g), 32'(grp_irq), 32'h1 << g);
            wr(AW'(b * 16 + 4), 32'hFFFF_FFFF);
        end
        @(negedge clk);
        src_lvl = '0;
    endtask

    task automatic t_level();
        wr(8'h00, 32'h0000_FF00);
        @(negedge clk);
        src_lvl[8] = 1'b1; src_lvl[12] = 1'b1;
        #1 chk("R6 two sources high", 32'(grp_irq), 32'h2);
        src_lvl[8] = 1'b0;
        #1 chk("R6 one source still high", 32'(grp_irq), 32'h2);
        src_lvl[12] = 1'b0;
        #1 chk("R6 all low drops line", 32'(grp_irq), 32'h0);
        src_lvl[20] = 1'b1;
        #1 chk("R6 disabled source ignored", 32'(grp_irq), 32'h0);
        src_lvl = '0;
        clear_all();
    endtask

    task automatic t_status();
        logic [31:0] d;
        @(negedge clk);
        src_lvl = {16'hA5C3, 32'h1234_5678, 32'hDEAD_BEEF};
        rd(8'h0C, d);
        chk("R7 status bank0 raw", d, 32'hDEAD_BEEF);
        rd(8'h1C, d);
        chk("R7 status bank1 raw", d, 32'h1234_5678);
        rd(8'h2C, d);
        chk("R10 status partial bank", d, 32'h0000_A5C3);
        chk("R7 status with no enables, lines low", 32'(grp_irq), 32'h0);
    endtask

    task automatic t_undecoded();
        logic [31:0] d;
        wr(8'h00, 32'h0000_00FF);
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h01, 32'hFFFF_FFFF);
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'h34, 32'hFFFF_FFFF);
        rd(8'h00, d);
        chk("R9 ignored writes keep enables", d, 32'h0000_00FF);
        chk("R9 line unchanged", 32'(grp_irq), 32'h1);
        rd(8'h08, d);
        chk("R9 offset 0x8 reads zero", d, 32'h0);
        rd(8'h00, d);
        rd(8'h3C, d);
        chk("R9 out-of-range bank reads zero", d, 32'h0);
        rd(8'h1C, d);
        rd(8'h05, d);
        chk("R9 misaligned offset reads zero", d, 32'h0);
        clear_all();
    endtask

    task automatic t_partial();
        logic [31:0] d;
        @(negedge clk);
        src_lvl = '1;
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, d);
        chk("R10 dead lanes hold no enables", d, 32'h0000_FFFF);
        chk("R10 partial bank lines", 32'(grp_irq), 32'h300);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h10, 32'hFFFF_FFFF);
        #1 chk("R5 all lines high", 32'(grp_irq), 32'h3FF);
        wr(8'h24, 32'hFFFF_FFFF);
        rd(8'h24, d);
        chk("R3 partial bank cleared", d, 32'h0);
        clear_all();
        @(negedge clk);
        src_lvl = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_clear();
        t_map();
        t_level();
        t_status();
        t_undecoded();
        t_partial();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule